// File: doc/BRIEF.md
# Handshake-terminated bus write sequencer

This block is a bus master that performs one write of a word or of a single byte on an asynchronous bus. Each slave ends the transfer with an acknowledge or a bus-error signal. The block runs on a clock at twice the bus rate. Every tick of that clock is one half-state of the bus cycle, so the cycle steps through the states S0 to S4 and then takes one of two endings. The block drives the address, the write data, the data output enable, an address strobe, a general data strobe, strobes for the upper and lower byte lanes, and read/write lines. All strobes are active low.

A requester offers a write on a valid/ready port. `req_ready` is high only while the sequencer is idle. A request is taken on the edge where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` high for as long as it likes, and nothing is taken while `req_ready` is low. Address, data and byte selects are captured at acceptance, so the request fields are free to change afterwards.

The acknowledge and bus-error inputs pass through a synchronizer. They are judged only at the end of S4 and at the end of each whole-clock wait state. An acknowledge, with or without bus error, ends the cycle normally. A bus error that arrives alone ends it through one extra half-state and raises an error flag. `done` pulses for one tick at the end of each cycle.

Top module: `wr_seq_ctrl`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `as_n`, `ds_n`, `uds_n` and `lds_n` are high, `rw_n` and `ext_rw_n` are high, `bus_data_oe` is low, `busy` is low and `req_ready` is high.
- R2: From the accepting edge until `done`, `bus_addr` and `bus_data` hold the accepted address and data, whatever the request inputs do meanwhile.
- R3: Call the accepting edge edge 0, with S0 in the tick after it. In S0 and S1 the address is driven, `as_n` is high and `rw_n` is high. From S2 (the tick after edge 2) `as_n` is low and `rw_n` and `ext_rw_n` are low.
- R4: From S3 onwards `bus_data_oe` is high, and it stays high until the cycle returns to idle.
- R5: From S4 onwards `ds_n` is low. `uds_n` is low only if `req_sel[1]` was set, and this selects the upper byte `data[15:8]`. `lds_n` is low only if `req_sel[0]` was set, and this selects the lower byte `data[7:0]`.
- R6: The termination decision is made only at edge 5 (the end of S4) and then at every second edge after it (7, 9, ...). If neither termination input is seen, two wait ticks are added and every output stays as in S4.
- R7: When acknowledge is seen (alone or with bus error) at decision edge d, the outputs stay unchanged in the ticks after edges d and d+1. In the tick after d+2 all strobes are high while `rw_n` stays low and `bus_data_oe` stays high. After edge d+3 the block is idle, with `done` high and `err` low for that one tick.
- R8: When only bus error is seen at decision edge d, the S4 outputs are held through the ticks after edges d to d+3. After edge d+4 the block is idle, with `done` and `err` both high for that one tick.
- R9: `busy` is high from S0 until the final state. While `busy` is high, `req_ready` is low and no request is taken.
- R10: `ack_n` and `berr_n` are sampled by two flops. A level applied between edges j and j+1 is seen at the first decision edge d with d >= j+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, one tick per half-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_sel | input | 2 | Byte-lane select: bit 1 upper, bit 0 lower |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-tick end-of-cycle pulse |
| err | output | 1 | With `done`: cycle ended by bus error |
| bus_addr | output | ADDR_W | Captured address |
| bus_data | output | DATA_W | Captured write data |
| bus_data_oe | output | 1 | Data bus output enable |
| as_n | output | 1 | Address strobe, active low |
| rw_n | output | 1 | Read/write, low means write |
| ext_rw_n | output | 1 | Extended read/write, follows `rw_n` |
| ds_n | output | 1 | General data strobe, active low |
| uds_n | output | 1 | Upper byte strobe, active low |
| lds_n | output | 1 | Lower byte strobe, active low |
| ack_n | input | 1 | Slave acknowledge, asynchronous, active low |
| berr_n | input | 1 | Bus error, asynchronous, active low |

## Verification
Random writes vary the address, data and byte selects. They also vary the tick at which the slave responds and the type of response: acknowledge, bus error, or both together. A response placed right at the synchronizer boundary (ticks 2 versus 3, 4 versus 5) shows whether the decision is made at the correct edge and whether the wait states come as whole clocks. A bus error alone and a bus error with acknowledge take different endings, and this checks the priority of acknowledge and the one-tick-longer error tail. Changing or holding `req_valid` and the request fields during a cycle checks capture and back-pressure.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4,
    ST_W1, ST_W2,
    ST_A5, ST_A6, ST_A7,
    ST_E5, ST_E6, ST_E7, ST_E8
  } wseq_state_e;

  typedef struct packed {
    logic as_n;
    logic rw_n;
    logic ds_n;
    logic uds_n;
    logic lds_n;
    logic oe;
  } bus_drive_t;

endpackage

// File: rtl/wseq_sync.sv
module wseq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q[0] <= '1;
    else        q[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '1;
      else        q[i] <= q[i-1];
    end

    // R10
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q[i] == $past(q[i-1]));
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/wseq_fsm.sv
module wseq_fsm
  import wseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ack_seen,
  input  logic        berr_seen,
  output wseq_state_e state,
  output logic        done,
  output logic        err
);
  wseq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_S0;
      ST_S0:   nxt = ST_S1;
      ST_S1:   nxt = ST_S2;
      ST_S2:   nxt = ST_S3;
      ST_S3:   nxt = ST_S4;
      ST_S4, ST_W2: begin
        if (ack_seen)       nxt = ST_A5;
        else if (berr_seen) nxt = ST_E5;
        else                nxt = ST_W1;
      end
      ST_W1:   nxt = ST_W2;
      ST_A5:   nxt = ST_A6;
      ST_A6:   nxt = ST_A7;
      ST_A7:   nxt = ST_IDLE;
      ST_E5:   nxt = ST_E6;
      ST_E6:   nxt = ST_E7;
      ST_E7:   nxt = ST_E8;
      ST_E8:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_A7) || (state == ST_E8);
      err   <= (state == ST_E8);
    end
  end

  // R6
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_S4 || state == ST_W2) && !ack_seen && !berr_seen) |=> state == ST_W1);

  // R7
  ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(state) == ST_A7);

  // R8
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && $past(state) == ST_E8));
endmodule

// File: rtl/wseq_drive.sv
module wseq_drive
  import wseq_pkg::*;
(
  input  wseq_state_e state,
  input  logic [1:0]  sel,
  output bus_drive_t  drv
);
  always_comb begin
    drv = '{as_n: 1'b1, rw_n: 1'b1, ds_n: 1'b1, uds_n: 1'b1, lds_n: 1'b1, oe: 1'b0};
    unique case (state)
      ST_S2: begin
        drv.as_n = 1'b0;
        drv.rw_n = 1'b0;
      end
      ST_S3: begin
        drv.as_n = 1'b0;
        drv.rw_n = 1'b0;
        drv.oe   = 1'b1;
      end
      ST_S4, ST_W1, ST_W2, ST_A5, ST_A6, ST_E5, ST_E6, ST_E7, ST_E8: begin
        drv.as_n  = 1'b0;
        drv.rw_n  = 1'b0;
        drv.oe    = 1'b1;
        drv.ds_n  = 1'b0;
        drv.uds_n = ~sel[1];
        drv.lds_n = ~sel[0];
      end
      ST_A7: begin
        drv.rw_n = 1'b0;
        drv.oe   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wr_seq_ctrl.sv
module wr_seq_ctrl
  import wseq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_sel,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_data_oe,
  output logic              as_n,
  output logic              rw_n,
  output logic              ext_rw_n,
  output logic              ds_n,
  output logic              uds_n,
  output logic              lds_n,
  input  logic              ack_n,
  input  logic              berr_n
);
  localparam int TERM_W = 2;

  wseq_state_e       state;
  bus_drive_t        drv;
  logic [TERM_W-1:0] term_s;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        sel_q;
  logic              take;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      sel_q  <= '0;
    end else if (take) begin
      addr_q <= req_addr;
      data_q <= req_data;
      sel_q  <= req_sel;
    end
  end

  wseq_sync #(.WIDTH(TERM_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({berr_n, ack_n}),
    .dout (term_s)
  );

  wseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .ack_seen (!term_s[0]),
    .berr_seen(!term_s[1]),
    .state    (state),
    .done     (done),
    .err      (err)
  );

  wseq_drive u_drive (
    .state(state),
    .sel  (sel_q),
    .drv  (drv)
  );

  assign bus_addr    = addr_q;
  assign bus_data    = data_q;
  assign bus_data_oe = drv.oe;
  assign as_n        = drv.as_n;
  assign rw_n        = drv.rw_n;
  assign ext_rw_n    = drv.rw_n;
  assign ds_n        = drv.ds_n;
  assign uds_n       = drv.uds_n;
  assign lds_n       = drv.lds_n;

  // R2
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_data)));

  // R3
  strobe_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> !rw_n);

  // R5
  ds_inside_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n |-> (!as_n && bus_data_oe));

  // R9
  no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(state) || state != ST_S0);
endmodule

// File: tb/wr_seq_ctrl_test.sv
module wr_seq_ctrl_test;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0]    req_sel = '0;
  logic          busy, done, err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          bus_data_oe, as_n, rw_n, ext_rw_n, ds_n, uds_n, lds_n;
  logic          ack_n = 1'b1;
  logic          berr_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wr_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_sel(req_sel),
    .busy(busy), .done(done), .err(err), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_data_oe(bus_data_oe), .as_n(as_n), .rw_n(rw_n), .ext_rw_n(ext_rw_n),
    .ds_n(ds_n), .uds_n(uds_n), .lds_n(lds_n), .ack_n(ack_n), .berr_n(berr_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // first decision edge that sees a response driven after edge j (R6, R10)
  function automatic int first_dec(input int j);
    int d = 5;
    while (d < j + 3) d += 2;
    return d;
  endfunction

  // expected {as,rw,ds,uds,lds,oe,busy,done,err} in the tick after edge t
  function automatic logic [8:0] exp_out(input int t, input int d, input int kind,
                                         input logic [1:0] sel);
    int  end_t  = (kind == 1) ? d + 4 : d + 3;
    int  end_st = (kind == 1) ? d + 4 : d + 2;
    logic s_as  = !(t >= 2 && t < end_st);
    logic s_ds  = !(t >= 4 && t < end_st);
    logic s_rw  = !(t >= 2 && t < end_t);
    logic s_oe  = (t >= 3 && t < end_t);
    return {s_as, s_rw, s_ds, s_ds | ~sel[1], s_ds | ~sel[0], s_oe,
            t < end_t, t == end_t, (t == end_t) && (kind == 1)};
  endfunction

  function automatic string tag_of(input int t, input int d, input int kind);
    if (t < 3)  return "R3";
    if (t == 3) return "R4";
    if (t < d)  return "R5 R6 R10";
    return (kind == 1) ? "R8" : "R7";
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " idle strobes"}, {as_n, ds_n, uds_n, lds_n}, 4'hF);
    chk({tag, " idle rw"}, {rw_n, ext_rw_n}, 2'b11);
    chk({tag, " idle oe/busy/ready/done"}, {bus_data_oe, busy, req_ready, done}, 4'b0010);
  endtask

  // kind: 0 ack, 1 bus error alone, 2 both
  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] dt,
                           input logic [1:0] sel, input int j, input int kind,
                           input bit hold_valid);
    int d = first_dec(j);
    int end_t = (kind == 1) ? d + 4 : d + 3;
    @(negedge clk);
    check_idle("R1");
    req_valid = 1'b1; req_addr = a; req_data = dt; req_sel = sel;
    @(posedge clk);                      // edge 0: accepted
    for (int t = 0; t <= end_t; t++) begin
      @(negedge clk);
      chk({tag_of(t, d, kind), " bus"}, {as_n, rw_n, ds_n, uds_n, lds_n, bus_data_oe, busy, done, err},
          exp_out(t, d, kind, sel));
      chk("R3 ext_rw", ext_rw_n, rw_n);
      if (t < end_t) begin
        chk("R2 addr", bus_addr, a);
        chk("R2 data", bus_data, dt);
        chk("R9 ready", req_ready, 1'b0);
      end
      if (hold_valid && t < end_t - 2) begin
        req_valid = 1'b1; req_addr = $urandom; req_data = $urandom; req_sel = $urandom;
      end else begin
        req_valid = 1'b0; req_addr = $urandom; req_data = $urandom;
      end
      if (t == j) begin
        if (kind != 1) ack_n = 1'b0;
        if (kind != 0) berr_n = 1'b0;
      end
    end
    ack_n = 1'b1; berr_n = 1'b1;
    @(negedge clk);
    chk("R7 R8 done pulse", {done, err}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    // directed corners
    run_write(24'h00_1000, 16'hA55A, 2'b11, 0, 0, 1'b0); // earliest ack, no wait
    run_write(24'h00_2002, 16'h1234, 2'b01, 2, 0, 1'b0); // last tick without wait
    run_write(24'h00_3004, 16'h5678, 2'b10, 3, 0, 1'b0); // one wait clock
    run_write(24'h00_4006, 16'h9ABC, 2'b11, 4, 2, 1'b1); // both, one wait, valid held
    run_write(24'h00_5008, 16'hDEF0, 2'b01, 0, 1, 1'b0); // bus error alone
    run_write(24'h00_600A, 16'h0F0F, 2'b10, 9, 1, 1'b1); // error after waits
    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [1:0] s = 2'($urandom_range(1, 3));
      run_write(AW'($urandom), DW'($urandom), s, int'($urandom_range(0, 14)),
                int'($urandom_range(0, 2)), 1'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule